// File: doc/BRIEF.md
# Asynchronous serial port with RTS/CTS handshake (DCE side)

This block is a full-duplex asynchronous serial port that sits on the device side of a host link. It takes bytes from an internal byte stream and sends them as serial frames on `txd`. It also recovers bytes from serial frames arriving on `rxd` and presents them on a second byte stream. Both lines run at a fixed 115200 baud with one start bit, eight data bits, no parity and one stop bit.

All bit timing comes from one 16x oversampling tick. A fractional accumulator derives that tick from the system clock frequency parameter. The transmitter and receiver use the tick independently, so neither direction waits on or disturbs the other. Flow control uses two active-low lines. The host's request line `rts_n` is an input that permits the block to start a new frame toward the host. The block drives `cts_n` to tell the host whether it may send. Setting `FLOW_EN` to 0 gives a two-wire port: `rts_n` is ignored and `cts_n` stays asserted.

Both byte streams use valid/ready. A transfer happens on a rising clock edge where both valid and ready are high. The transmit side raises `tx_ready` only when it has no byte pending, so an upstream source simply holds `tx_data` until it is taken. The receive side holds `rx_valid` and `rx_data` steady until the consumer raises `rx_ready`. While it waits, it signals back-pressure to the host through `cts_n`.

Top module: `uart_dce_port`

## Requirements
- R1: A transmitted frame is one low start bit, then the eight data bits least significant bit first, then one high stop bit. Each bit lasts 16 periods of the 16x tick, which averages CLK_HZ/BAUD clock cycles (434 at 50 MHz and 115200 baud).
- R2: `txd` is high whenever no frame is being sent. After reset, `txd`=1, `tx_ready`=1, `rx_valid`=0, `cts_n`=0 and `frame_err`=0.
- R3: A byte is taken when `tx_valid` and `tx_ready` are both high at a clock edge. `tx_ready` then stays low until that byte's stop bit has been fully sent.
- R4: The receiver oversamples `rxd` at 16x. It confirms a start bit only if the line is still low half a bit after the falling edge, so a low pulse shorter than that produces no byte and no error. It samples each data bit at its centre and presents the byte on `rx_data` with `rx_valid`.
- R5: A new frame starts only while `rts_n` is low (asserted). A byte taken while `rts_n` is high waits, `txd` stays high, and the frame goes out after `rts_n` falls.
- R6: If `rts_n` is raised during a frame, that frame still completes unchanged.
- R7: Transmission and reception run at the same time without affecting each other's data or timing.
- R8: A low level at the stop-bit sample point discards the byte and raises `frame_err` for exactly one clock cycle. The receiver then ignores `rxd` until the line has gone high again.
- R9: While `rx_valid` is high and `rx_ready` is low, `rx_valid` stays high and `rx_data` stays unchanged. A byte completed while the holding register is full and unread is dropped, and the held byte is kept.
- R10: With `FLOW_EN`=1, `cts_n` is high exactly while the receive holding register is full (equal to `rx_valid`) and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter can take a byte |
| tx_data | input | DATA_BITS | Byte to transmit |
| rx_valid | output | 1 | Received byte held |
| rx_ready | input | 1 | Consumer takes the held byte |
| rx_data | output | DATA_BITS | Received byte |
| frame_err | output | 1 | One-cycle pulse on a bad stop bit |
| rxd | input | 1 | Serial data from host |
| txd | output | 1 | Serial data to host |
| rts_n | input | 1 | Host request line, low permits sending |
| cts_n | output | 1 | Clear to send to host, low means host may send |

## Verification
A wrong transmit state shows on `txd` within one bit time. The symptoms are a start bit that begins while `rts_n` is high, a bit cell shorter or longer than 434 cycles, or a misplaced data bit. These show up in the byte the bench decodes from the line. A wrong receive state shows about one frame later: as a wrong byte, a missing or extra `rx_valid`, a `frame_err` pulse where none belongs, or `cts_n` disagreeing with `rx_valid` in the same cycle the holding register changes. The harder cases are an overrun that overwrites the held byte, and a receiver that restarts while the line is still low after a framing error. Both are checked one frame after the offending stimulus, by reading the held byte and sending a clean follow-up frame.

// File: rtl/uart_dce_pkg.sv
package uart_dce_pkg;
  // Transmit sequencer states
  typedef enum logic [2:0] {
    TX_IDLE,
    TX_PEND,
    TX_START,
    TX_DATA,
    TX_STOP
  } tx_state_t;

  // Receive sequencer states
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_RECOVER
  } rx_state_t;
endpackage

// File: rtl/uart_tick_gen.sv
// Fractional divider: emits a one-cycle tick at BAUD*OVS per second on average.
module uart_tick_gen #(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned BAUD   = 115_200,
  parameter int unsigned OVS    = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned STEP  = BAUD * OVS;
  localparam int          ACC_W = $clog2(CLK_HZ) + 2;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sum;

  assign sum = acc + ACC_W'(STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      tick <= 1'b0;
    end else if (sum >= ACC_W'(CLK_HZ)) begin
      acc  <= sum - ACC_W'(CLK_HZ);
      tick <= 1'b1;
    end else begin
      acc  <= sum;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_sync.sv
// Multi-flop synchronizer for an asynchronous input.
module uart_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_tx_engine.sv
// Serializer: start bit, data LSB first, stop bit; each bit OVS ticks long.
module uart_tx_engine
  import uart_dce_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OVS       = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 may_start,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic [DATA_BITS-1:0] s_data,
  output logic                 txd,
  output logic                 start_pulse
);
  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_BITS - 1);

  tx_state_t            state;
  logic [DATA_BITS-1:0] shreg;
  logic [CNT_W-1:0]     ocnt;
  logic [BIT_W-1:0]     bcnt;
  logic                 cell_end;

  assign s_ready  = (state == TX_IDLE);
  assign cell_end = tick && (ocnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= TX_IDLE;
      shreg       <= '0;
      ocnt        <= '0;
      bcnt        <= '0;
      txd         <= 1'b1;
      start_pulse <= 1'b0;
    end else begin
      start_pulse <= 1'b0;
      if (tick && state inside {TX_START, TX_DATA, TX_STOP} && !cell_end)
        ocnt <= ocnt + 1'b1;
      unique case (state)
        TX_IDLE: begin
          txd <= 1'b1;
          if (s_valid) begin
            shreg <= s_data;
            state <= TX_PEND;
          end
        end
        TX_PEND: begin
          txd <= 1'b1;
          if (tick && may_start) begin
            txd         <= 1'b0;
            ocnt        <= '0;
            start_pulse <= 1'b1;
            state       <= TX_START;
          end
        end
        TX_START: begin
          if (cell_end) begin
            ocnt  <= '0;
            bcnt  <= '0;
            txd   <= shreg[0];
            shreg <= shreg >> 1;
            state <= TX_DATA;
          end
        end
        TX_DATA: begin
          if (cell_end) begin
            ocnt <= '0;
            if (bcnt == BIT_LAST) begin
              txd   <= 1'b1;
              state <= TX_STOP;
            end else begin
              bcnt  <= bcnt + 1'b1;
              txd   <= shreg[0];
              shreg <= shreg >> 1;
            end
          end
        end
        TX_STOP: begin
          if (cell_end) begin
            ocnt  <= '0;
            state <= TX_IDLE;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_engine.sv
// Deserializer with mid-bit start confirmation, centre sampling,
// stop-bit check and a one-byte holding register on a valid/ready stream.
module uart_rx_engine
  import uart_dce_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OVS       = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 line,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic [DATA_BITS-1:0] m_data,
  output logic                 frame_err
);
  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVS / 2 - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_BITS - 1);

  rx_state_t            state;
  logic [DATA_BITS-1:0] shreg;
  logic [DATA_BITS-1:0] hold;
  logic                 full;
  logic [CNT_W-1:0]     ocnt;
  logic [BIT_W-1:0]     bcnt;
  logic                 can_load;

  assign m_valid  = full;
  assign m_data   = hold;
  assign can_load = !full || m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      shreg     <= '0;
      hold      <= '0;
      full      <= 1'b0;
      ocnt      <= '0;
      bcnt      <= '0;
      frame_err <= 1'b0;
    end else begin
      frame_err <= 1'b0;
      if (full && m_ready) full <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          if (tick && !line) begin
            ocnt  <= '0;
            state <= RX_START;
          end
        end
        RX_START: begin
          if (tick) begin
            if (ocnt == CNT_MID) begin
              ocnt  <= '0;
              bcnt  <= '0;
              state <= line ? RX_IDLE : RX_DATA;
            end else begin
              ocnt <= ocnt + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            if (ocnt == CNT_LAST) begin
              ocnt  <= '0;
              shreg <= {line, shreg[DATA_BITS-1:1]};
              if (bcnt == BIT_LAST) state <= RX_STOP;
              else                  bcnt  <= bcnt + 1'b1;
            end else begin
              ocnt <= ocnt + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            if (ocnt == CNT_LAST) begin
              ocnt <= '0;
              if (line) begin
                state <= RX_IDLE;
                if (can_load) begin
                  hold <= shreg;
                  full <= 1'b1;
                end
              end else begin
                frame_err <= 1'b1;
                state     <= RX_RECOVER;
              end
            end else begin
              ocnt <= ocnt + 1'b1;
            end
          end
        end
        RX_RECOVER: begin
          if (line) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_dce_port.sv
// Full-duplex serial port, device side, with active-low RTS/CTS handshake.
module uart_dce_port #(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned BAUD      = 115_200,
  parameter int          DATA_BITS = 8,
  parameter int          OVS       = 16,
  parameter int          SYNC_FF   = 2,
  parameter bit          FLOW_EN   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic [DATA_BITS-1:0] tx_data,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 frame_err,
  input  logic                 rxd,
  output logic                 txd,
  input  logic                 rts_n,
  output logic                 cts_n
);
  logic tick;
  logic rxd_s;
  logic rts_ok;
  logic tx_start_pulse;

  uart_tick_gen #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .OVS(OVS)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  uart_sync #(.STAGES(SYNC_FF), .RESET_VAL(1'b1)) u_rxd_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s)
  );

  generate
    if (FLOW_EN) begin : g_flow
      logic rts_s;
      uart_sync #(.STAGES(SYNC_FF), .RESET_VAL(1'b1)) u_rts_sync (
        .clk(clk), .rst_n(rst_n), .d(rts_n), .q(rts_s)
      );
      assign rts_ok = !rts_s;
      assign cts_n  = rx_valid;
    end else begin : g_noflow
      assign rts_ok = 1'b1;
      assign cts_n  = 1'b0;
    end
  endgenerate

  uart_tx_engine #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .may_start(rts_ok),
    .s_valid(tx_valid), .s_ready(tx_ready), .s_data(tx_data),
    .txd(txd), .start_pulse(tx_start_pulse)
  );

  uart_rx_engine #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line(rxd_s),
    .m_valid(rx_valid), .m_ready(rx_ready), .m_data(rx_data),
    .frame_err(frame_err)
  );
endmodule

// File: rtl/uart_dce_port_chk.sv
module uart_dce_port_chk #(
  parameter int DATA_BITS = 8,
  parameter bit FLOW_EN   = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tx_ready,
  input logic                 txd,
  input logic                 rx_valid,
  input logic                 rx_ready,
  input logic [DATA_BITS-1:0] rx_data,
  input logic                 frame_err,
  input logic                 cts_n,
  input logic                 rts_ok,
  input logic                 tx_start_pulse
);
  // R2: an idle transmitter keeps the line high
  assert_line_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);

  // R5: a frame begins only when the synchronized request was asserted
  assert_start_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start_pulse |-> $past(rts_ok));

  // R8: framing error is a single-cycle pulse
  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  // R8: a bad frame never produces a byte
  assert_err_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && !rx_valid) |=> !rx_valid);

  // R9: held byte stays put under back-pressure
  assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  generate
    if (FLOW_EN) begin : g_cts
      // R10: clear-to-send deasserted exactly while the holding register is full
      assert_cts_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cts_n == rx_valid);
    end
  endgenerate
endmodule

bind uart_dce_port uart_dce_port_chk #(.DATA_BITS(DATA_BITS), .FLOW_EN(FLOW_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_ready(tx_ready), .txd(txd),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .frame_err(frame_err), .cts_n(cts_n), .rts_ok(rts_ok),
  .tx_start_pulse(tx_start_pulse)
);

// File: tb/test_uart_dce_port.sv
module test_uart_dce_port;
  localparam int BIT_CYC  = 434;
  localparam int HALF_CYC = 217;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_valid, tx_ready, rx_valid, rx_ready;
  logic [7:0] tx_data, rx_data;
  logic       frame_err, rxd, txd, rts_n, cts_n;

  always #10 clk = ~clk;

  uart_dce_port i_uart_dce_port (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .frame_err(frame_err), .rxd(rxd), .txd(txd),
    .rts_n(rts_n), .cts_n(cts_n)
  );

  int n_chk = 0, n_fail = 0;
  int cap_n = 0, exp_n = 0, stop_bad = 0, fe_cnt = 0;
  logic [7:0] cap    [0:63];
  logic [7:0] exp_tx [0:63];
  bit mon_on = 0;

  // Line level of frame bit idx (0 start, 1..8 data LSB first, 9 stop)
  function automatic logic frame_level(input logic [7:0] b, input int idx);
    if (idx == 0) return 1'b0;
    if (idx >= 9) return 1'b1;
    return b[idx-1];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Framing error pulse counter
  always @(negedge clk) if (frame_err === 1'b1) fe_cnt++;

  // Line monitor: decodes frames on txd
  initial begin
    logic [7:0] v;
    wait (mon_on);
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        repeat (HALF_CYC - 1) @(negedge clk);
        if (txd === 1'b0) begin
          for (int k = 0; k < 8; k++) begin
            repeat (BIT_CYC) @(negedge clk);
            v[k] = txd;
          end
          repeat (BIT_CYC) @(negedge clk);
          if (txd !== 1'b1) stop_bad++;
          cap[cap_n[5:0]] = v;
          cap_n++;
        end
      end
    end
  end

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk);
    tx_data  = b;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    exp_tx[exp_n[5:0]] = b;
    exp_n++;
  endtask

  task automatic send_rx(input logic [7:0] b, input bit bad_stop);
    for (int i = 0; i < 10; i++) begin
      rxd = (i == 9 && bad_stop) ? 1'b0 : frame_level(b, i);
      repeat (BIT_CYC) @(negedge clk);
    end
    if (bad_stop) begin
      repeat (BIT_CYC) @(negedge clk);
      rxd = 1'b1;
      repeat (2 * BIT_CYC) @(negedge clk);
    end
    rxd = 1'b1;
  endtask

  task automatic read_rx();
    @(negedge clk);
    rx_ready = 1'b1;
    while (!rx_valid) @(negedge clk);
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic wait_caps(input int n);
    while (cap_n < n) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (190_000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] b;
    int base, fe0;
    void'($urandom(32'd1357));
    rst_n = 0; rxd = 1; rts_n = 1; tx_valid = 0; tx_data = 0; rx_ready = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    mon_on = 1;

    // R2: reset state
    chk(txd === 1'b1,       "R2 txd", txd, 1);
    chk(tx_ready === 1'b1,  "R2 tx_ready", tx_ready, 1);
    chk(rx_valid === 1'b0,  "R2 rx_valid", rx_valid, 0);
    chk(cts_n === 1'b0,     "R2 cts_n", cts_n, 0);
    chk(frame_err === 1'b0, "R2 frame_err", frame_err, 0);

    // R5 / R3: byte held while request deasserted
    push_tx(8'hA5);
    chk(tx_ready === 1'b0, "R3 tx_ready low after accept", tx_ready, 0);
    repeat (3 * BIT_CYC) @(negedge clk);
    chk(cap_n == 0 && txd === 1'b1, "R5 no frame while rts_n high", cap_n, 0);
    rts_n = 0;
    wait_caps(1);
    chk(cap[0] == 8'hA5, "R1 frame after rts_n low", cap[0], 8'hA5);
    chk(tx_ready === 1'b0, "R3 tx_ready low during stop bit", tx_ready, 0);
    while (!tx_ready) @(negedge clk);
    chk(txd === 1'b1, "R2 idle high after frame", txd, 1);

    // R7 / R1 / R4: concurrent random traffic both ways
    base = exp_n;
    fork
      begin
        for (int i = 0; i < 7; i++) push_tx(8'($urandom));
      end
      begin
        for (int i = 0; i < 7; i++) begin
          logic [7:0] r;
          r = 8'($urandom);
          send_rx(r, 1'b0);
          chk(rx_valid === 1'b1 && rx_data == r, "R7 rx during tx", rx_data, r);
          read_rx();
        end
      end
    join
    wait_caps(exp_n);
    for (int i = base; i < exp_n; i++)
      chk(cap[i] == exp_tx[i], "R1 tx byte under concurrent rx", cap[i], exp_tx[i]);
    chk(stop_bad == 0, "R1 stop bits high", stop_bad, 0);

    // R6: frame in progress completes after request drops
    base = cap_n;
    push_tx(8'h3E);
    while (txd !== 1'b0) @(negedge clk);
    repeat (3 * BIT_CYC) @(negedge clk);
    rts_n = 1;
    push_tx(8'hC1);
    repeat (3 * BIT_CYC) @(negedge clk);
    chk(cap_n == base + 1 && cap[base[5:0]] == 8'h3E, "R6 frame completed",
        cap[base[5:0]], 8'h3E);
    chk(cap_n == base + 1 && txd === 1'b1, "R5 next frame held", cap_n, base + 1);
    rts_n = 0;
    wait_caps(base + 2);
    chk(cap[(base + 1) & 63] == 8'hC1, "R5 held frame sent", cap[(base + 1) & 63], 8'hC1);

    // R1 / R4: extreme patterns both directions
    base = cap_n;
    fork
      begin push_tx(8'h00); push_tx(8'hFF); end
      begin
        send_rx(8'hFF, 1'b0);
        chk(rx_valid === 1'b1 && rx_data == 8'hFF, "R4 rx all ones", rx_data, 8'hFF);
        read_rx();
        send_rx(8'h00, 1'b0);
        chk(rx_valid === 1'b1 && rx_data == 8'h00, "R4 rx all zeros", rx_data, 8'h00);
        read_rx();
      end
    join
    wait_caps(base + 2);
    chk(cap[base[5:0]] == 8'h00, "R1 tx all zeros", cap[base[5:0]], 8'h00);
    chk(cap[(base + 1) & 63] == 8'hFF, "R1 tx all ones", cap[(base + 1) & 63], 8'hFF);

    // R9 / R10: back-pressure and overrun
    send_rx(8'h3C, 1'b0);
    chk(rx_valid === 1'b1 && rx_data == 8'h3C, "R9 held byte", rx_data, 8'h3C);
    chk(cts_n === 1'b1, "R10 cts_n high when full", cts_n, 1);
    send_rx(8'hC3, 1'b0);
    chk(rx_valid === 1'b1 && rx_data == 8'h3C, "R9 overrun keeps held byte", rx_data, 8'h3C);
    read_rx();
    chk(rx_valid === 1'b0, "R9 overrun byte dropped", rx_valid, 0);
    chk(cts_n === 1'b0, "R10 cts_n low when empty", cts_n, 0);

    // R8: framing error, long low, then recovery
    fe0 = fe_cnt;
    b = 8'($urandom);
    send_rx(b, 1'b1);
    chk(fe_cnt == fe0 + 1, "R8 one error pulse", fe_cnt - fe0, 1);
    chk(rx_valid === 1'b0, "R8 bad byte discarded", rx_valid, 0);
    send_rx(8'h96, 1'b0);
    chk(rx_valid === 1'b1 && rx_data == 8'h96, "R8 receive after recovery", rx_data, 8'h96);
    chk(fe_cnt == fe0 + 1, "R8 no extra error", fe_cnt - fe0, 1);
    read_rx();

    // R4: short low glitch is not a start bit
    fe0 = fe_cnt;
    rxd = 1'b0;
    repeat (80) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BIT_CYC) @(negedge clk);
    chk(rx_valid === 1'b0, "R4 glitch ignored", rx_valid, 0);
    chk(fe_cnt == fe0, "R4 glitch no error", fe_cnt - fe0, 0);
    send_rx(8'h81, 1'b0);
    chk(rx_valid === 1'b1 && rx_data == 8'h81, "R4 byte after glitch", rx_data, 8'h81);
    read_rx();

    summary();
  end
endmodule